// File: doc/BRIEF.md
# Mode-Selected Arithmetic Logic Unit

A purely combinational ALU of parameterised width (four bits by default). A three-bit select chooses one of twelve operations. The top select bit picks between an arithmetic section and a bitwise logic section. The two lower bits pick the operation within that section.

The arithmetic section is a single ripple adder. Its first operand is always A. Its second operand is taken, bit by bit, from one of four sources: zero, B, the complement of B, or all ones. The carry input acts as a fourth select bit, so one adder yields eight operations: transfer, increment, add, add-plus-one, add-complement, subtract, decrement and transfer-with-carry.

The logic section gives AND, OR, XOR and the complement of A. The block reports the result, a carry-out, a two's-complement overflow flag and a zero flag. It is used as the function unit between operand buses and a destination register, and that register lives outside the block.

Top module: `mode_alu`

## Requirements
- R1: With sel_i[2]=0, f_o equals (a_i + Y + cin_i) modulo 2^WIDTH, where Y is the adder's second operand defined in R2.
- R2: In arithmetic mode, Y is chosen per bit by sel_i[1:0]: 00 gives all zeros, 01 gives b_i, 10 gives ~b_i, 11 gives all ones.
- R3: In arithmetic mode, cout_o is bit WIDTH of the full sum a_i + Y + cin_i.
- R4: In arithmetic mode, ovf_o is 1 exactly when the carry into the MSB differs from the carry out of it. This is the same as a_i and Y sharing a sign bit that differs from the sign bit of f_o.
- R5: With sel_i[2]=1, sel_i[1:0] selects the logic result: 00 gives a_i & b_i, 01 gives a_i | b_i, 10 gives a_i ^ b_i, 11 gives ~a_i.
- R6: In logic mode, cout_o and ovf_o are 0 and cin_i has no effect on any output.
- R7: zero_o is 1 exactly when f_o is all zeros, in both modes.
- R8: Both arithmetic transfer codes return a_i unchanged. Select 000 with cin_i=0 gives cout_o=0. Select 011 with cin_i=1 gives cout_o=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry input; extra function select in arithmetic mode |
| sel_i | input | 3 | Bit 2: mode (0 arithmetic, 1 logic); bits 1:0: function |
| f_o | output | WIDTH | Result |
| cout_o | output | 1 | Carry out of the MSB (arithmetic only) |
| ovf_o | output | 1 | Signed overflow (arithmetic only) |
| zero_o | output | 1 | Result is all zeros |

## Verification
The block holds no state. A faulty operand selector, carry stage or section mux shows up on the outputs as soon as the inputs settle, with no clock delay. A broken carry link shows only for operand patterns that propagate a carry through that stage. For that reason, every select code, carry value and operand pair at the default width is compared against a model built from the requirements. A wrong MSB carry stage appears as an overflow disagreement even when the sum bits match, so overflow is compared on every vector.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    LG_AND = 2'b00,
    LG_OR  = 2'b01,
    LG_XOR = 2'b10,
    LG_NOT = 2'b11
  } logic_fn_e;

  typedef enum logic [1:0] {
    YS_ZERO = 2'b00,
    YS_B    = 2'b01,
    YS_BN   = 2'b10,
    YS_ONES = 2'b11
  } ysel_e;

  localparam int SEL_W = 3;
  localparam int MODE_BIT = 2;
endpackage

// File: rtl/alu_b_sel.sv
module alu_b_sel
  import alu_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       fn_i,
  output logic [WIDTH-1:0] y_o
);
  // Y = B*s0 + B'*s1 per bit
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign y_o[i] = (b_i[i] & fn_i[0]) | (~b_i[i] & fn_i[1]);
  end

  always_comb begin
    // R2
    y_sel_chk: assert (
      (fn_i == YS_ZERO && y_o == '0) ||
      (fn_i == YS_B    && y_o == b_i) ||
      (fn_i == YS_BN   && y_o == ~b_i) ||
      (fn_i == YS_ONES && y_o == '1))
      else $error("operand selector mismatch");
  end
endmodule

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);
  localparam int XW = WIDTH + 1;

  logic [WIDTH:0] c;
  assign c[0] = cin_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_fa
    assign sum_o[i] = a_i[i] ^ y_i[i] ^ c[i];
    assign c[i+1]   = (a_i[i] & y_i[i]) | (c[i] & (a_i[i] ^ y_i[i]));
  end

  assign cout_o = c[WIDTH];
  assign ovf_o  = c[WIDTH] ^ c[WIDTH-1];

  always_comb begin
    // R1
    sum_chk: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, y_i} + XW'(cin_i)))
      else $error("ripple sum mismatch");
    // R4
    ovf_sign_chk: assert (ovf_o ==
      ((a_i[WIDTH-1] == y_i[WIDTH-1]) && (sum_o[WIDTH-1] != a_i[WIDTH-1])))
      else $error("overflow flag inconsistent with signs");
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       fn_i,
  output logic [WIDTH-1:0] res_o
);
  always_comb begin
    unique case (logic_fn_e'(fn_i))
      LG_AND:  res_o = a_i & b_i;
      LG_OR:   res_o = a_i | b_i;
      LG_XOR:  res_o = a_i ^ b_i;
      default: res_o = ~a_i;
    endcase
  end

  always_comb begin
    // R5
    not_a_chk: assert (fn_i != LG_NOT || (res_o ^ a_i) == '1)
      else $error("complement result wrong");
    // R5
    or_cover_chk: assert (fn_i != LG_OR || ((res_o & a_i) == a_i && (res_o & b_i) == b_i))
      else $error("OR result misses operand bits");
  end
endmodule

// File: rtl/mode_alu.sv
module mode_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [WIDTH-1:0] f_o,
  output logic             cout_o,
  output logic             ovf_o,
  output logic             zero_o
);
  logic             logic_mode;
  logic [WIDTH-1:0] y;
  logic [WIDTH-1:0] arith_f;
  logic [WIDTH-1:0] logic_f;
  logic             arith_c;
  logic             arith_v;

  assign logic_mode = sel_i[MODE_BIT];

  alu_b_sel #(.WIDTH(WIDTH)) u_bsel (
    .b_i  (b_i),
    .fn_i (sel_i[1:0]),
    .y_o  (y)
  );

  alu_arith #(.WIDTH(WIDTH)) u_arith (
    .a_i    (a_i),
    .y_i    (y),
    .cin_i  (cin_i),
    .sum_o  (arith_f),
    .cout_o (arith_c),
    .ovf_o  (arith_v)
  );

  alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i   (a_i),
    .b_i   (b_i),
    .fn_i  (sel_i[1:0]),
    .res_o (logic_f)
  );

  always_comb begin
    if (logic_mode) begin
      f_o    = logic_f;
      cout_o = 1'b0;
      ovf_o  = 1'b0;
    end else begin
      f_o    = arith_f;
      cout_o = arith_c;
      ovf_o  = arith_v;
    end
  end

  assign zero_o = ~|f_o;

  always_comb begin
    // R6
    logic_flags_chk: assert (!logic_mode || (!cout_o && !ovf_o))
      else $error("flags set in logic mode");
    // R7
    zero_flag_chk: assert (zero_o == ($countones(f_o) == 0))
      else $error("zero flag mismatch");
    // R8
    xfer_chk: assert (logic_mode || sel_i[1:0] != 2'b00 || cin_i || (f_o == a_i && !cout_o))
      else $error("transfer code altered operand");
  end
endmodule

// File: tb/sim_mode_alu.sv
module sim_mode_alu;
  localparam int W = 4;
  localparam int VW = 3 + 1 + W + W + W + 3;
  localparam int NV = 14;

  // {sel, cin, a, b, f, cout, ovf, zero}
  localparam logic [VW-1:0] VEC [NV] = '{
    {3'b000, 1'b0, 4'h5, 4'h9, 4'h5, 1'b0, 1'b0, 1'b0},
    {3'b000, 1'b1, 4'hF, 4'h0, 4'h0, 1'b1, 1'b0, 1'b1},
    {3'b001, 1'b0, 4'h7, 4'h1, 4'h8, 1'b0, 1'b1, 1'b0},
    {3'b001, 1'b1, 4'h9, 4'h6, 4'h0, 1'b1, 1'b0, 1'b1},
    {3'b010, 1'b0, 4'h6, 4'h3, 4'h2, 1'b1, 1'b0, 1'b0},
    {3'b010, 1'b1, 4'h3, 4'h5, 4'hE, 1'b0, 1'b0, 1'b0},
    {3'b010, 1'b1, 4'h8, 4'h1, 4'h7, 1'b1, 1'b1, 1'b0},
    {3'b011, 1'b0, 4'h0, 4'h5, 4'hF, 1'b0, 1'b0, 1'b0},
    {3'b011, 1'b0, 4'h4, 4'h5, 4'h3, 1'b1, 1'b0, 1'b0},
    {3'b011, 1'b1, 4'hA, 4'h5, 4'hA, 1'b1, 1'b0, 1'b0},
    {3'b100, 1'b1, 4'hC, 4'hA, 4'h8, 1'b0, 1'b0, 1'b0},
    {3'b101, 1'b1, 4'hC, 4'h3, 4'hF, 1'b0, 1'b0, 1'b0},
    {3'b110, 1'b0, 4'hC, 4'hC, 4'h0, 1'b0, 1'b0, 1'b1},
    {3'b111, 1'b0, 4'h5, 4'h0, 4'hA, 1'b0, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0] a, b, f;
  logic         cin, cout, ovf, zero;
  logic [2:0]   sel;

  mode_alu #(.WIDTH(W)) u0 (
    .a_i(a), .b_i(b), .cin_i(cin), .sel_i(sel),
    .f_o(f), .cout_o(cout), .ovf_o(ovf), .zero_o(zero)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic chk(string req, logic [W+2:0] act, logic [W+2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s sel=%b cin=%b a=%h b=%h: got {f,c,v,z}=%h expected %h",
               req, sel, cin, a, b, act, exp);
    end
  endtask

  function automatic logic [W+2:0] model(logic [2:0] s, logic ci, logic [W-1:0] x, logic [W-1:0] yb);
    logic [W-1:0] op2, r;
    logic [W:0]   full;
    logic         c, v;
    c = 1'b0;
    v = 1'b0;
    if (!s[2]) begin
      case (s[1:0])
        2'b00:   op2 = '0;
        2'b01:   op2 = yb;
        2'b10:   op2 = ~yb;
        default: op2 = '1;
      endcase
      full = {1'b0, x} + {1'b0, op2} + {{W{1'b0}}, ci};
      r = full[W-1:0];
      c = full[W];
      v = (x[W-1] == op2[W-1]) && (r[W-1] != x[W-1]);
    end else begin
      case (s[1:0])
        2'b00:   r = x & yb;
        2'b01:   r = x | yb;
        2'b10:   r = x ^ yb;
        default: r = ~x;
      endcase
    end
    return {r, c, v, (r == '0)};
  endfunction

  task automatic apply(logic [2:0] s, logic ci, logic [W-1:0] x, logic [W-1:0] yb);
    @(posedge clk);
    #2;
    sel = s; cin = ci; a = x; b = yb;
    #3;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : stim
    logic [W-1:0] f0;
    sel = '0; cin = 0; a = '0; b = '0;
    // idle inputs: transfer of zero, R7 and R8
    apply(3'b000, 1'b0, '0, '0);
    chk("R7", {f, cout, ovf, zero}, {4'h0, 1'b0, 1'b0, 1'b1});

    // table walk
    for (int k = 0; k < NV; k++) begin
      logic [VW-1:0] v;
      v = VEC[k];
      apply(v[VW-1 -: 3], v[VW-4], v[VW-5 -: W], v[VW-5-W -: W]);
      chk(v[VW-1] ? "R5" : "R1", {f, cout, ovf, zero}, v[W+2:0]);
    end

    // R2 operand source: A=0, cin=0 exposes Y directly
    for (int s = 0; s < 4; s++) begin
      apply(3'(s), 1'b0, '0, 4'h6);
      chk("R2", {1'b0, f}, {1'b0, (s == 0) ? 4'h0 : (s == 1) ? 4'h6 : (s == 2) ? 4'h9 : 4'hF});
    end

    // R3 R4 carry ripple through every stage: 0111+0001 and 1111+0001
    apply(3'b001, 1'b0, 4'h7, 4'h1);
    chk("R4", {f, cout, ovf, zero}, {4'h8, 1'b0, 1'b1, 1'b0});
    apply(3'b001, 1'b0, 4'hF, 4'h1);
    chk("R3", {f, cout, ovf, zero}, {4'h0, 1'b1, 1'b0, 1'b1});

    // R8 both transfer codes
    apply(3'b000, 1'b0, 4'hB, 4'h4);
    chk("R8", {f, cout, ovf, zero}, {4'hB, 1'b0, 1'b0, 1'b0});
    apply(3'b011, 1'b1, 4'hB, 4'h4);
    chk("R8", {f, cout, ovf, zero}, {4'hB, 1'b1, 1'b0, 1'b0});

    // R6 cin has no effect in logic mode
    for (int s = 4; s < 8; s++) begin
      apply(3'(s), 1'b0, 4'h9, 4'h5);
      f0 = f;
      apply(3'(s), 1'b1, 4'h9, 4'h5);
      chk("R6", {f, cout, ovf, zero}, {f0, 1'b0, 1'b0, (f0 == '0)});
    end

    // exhaustive sweep against requirement model
    for (int s = 0; s < 8; s++) begin
      for (int ci = 0; ci < 2; ci++) begin
        for (int x = 0; x < 16; x++) begin
          for (int yb = 0; yb < 16; yb++) begin
            apply(3'(s), 1'(ci), 4'(x), 4'(yb));
            chk((s < 4) ? "R1" : "R5", {f, cout, ovf, zero},
                model(3'(s), 1'(ci), 4'(x), 4'(yb)));
          end
        end
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule